// File: doc/BRIEF.md
# Toggle Bit Completion Poller

This block runs on the host side of a parallel flash interface. It finds out whether an embedded program or erase operation inside the flash has finished. A single-cycle start pulse latches the status address. The block then issues reads to that address through a request/acknowledge read port and watches status bit 6 of each returned word. A flash that is busy flips this bit on every read. A flash that has finished returns a steady value.

Reads are always taken in pairs, and the block decides only after the second read of a pair. If bit 6 matches across the pair, the operation has finished. If it differs while the timeout flag (bit 5) is low, the block polls again. If it differs while bit 5 is high, the block takes one more confirming pair, because the toggling may have stopped at the same moment the flag rose.

A failure can arise in two ways: the confirming pair still toggles, or the poll budget runs out. On failure the block writes the reset command F0h to the status address before it reports. An abort input returns the block to idle at any time. The next start always begins with a fresh pair of reads.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset the block is idle: busy_o, rd_req_o, wr_req_o and done_o are all low.
- R2: After start_i, the first two reads happen before any decision, and both go to the address on poll_addr_i when start_i was taken. No result is reported before the second read's acknowledge.
- R3: If bit 6 is equal in the two words of a pair, done_o pulses with pass_o high and no write is issued.
- R4: If bit 6 differs within a pair and bit 5 of the pair's second word is low, the block issues another pair of reads, until the poll budget is reached.
- R5: If bit 6 differs and bit 5 of the second word is high, exactly one more pair is read. If bit 6 is equal in that pair, the result is a pass.
- R6: If bit 6 still differs in the confirming pair, one write of data F0h is issued to the latched address. After its acknowledge, done_o pulses with pass_o low.
- R7: After MAX_POLLS consecutive toggling pairs with bit 5 low, the block takes the failure path of R6.
- R8: abort_i returns the block to idle on the next cycle. No result is reported, and the next start begins with a new first read.
- R9: done_o is high for exactly one cycle per completed operation. start_i is ignored while busy_o is high.
- R10: A read request stays high, with a stable address, until it is acknowledged or aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (one cycle) |
| abort_i | input | 1 | Abandon polling, return to idle |
| poll_addr_i | input | AW | Status address, latched at start |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Read data word |
| wr_req_o | output | 1 | Write request (reset command) |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data, F0h |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, valid with done_o |

## Verification
The bench builds the block with MAX_POLLS set to 4, AW set to 16 and DW set to 8. The small poll budget means a responder that never settles reaches the forced failure after eight reads. Random toggle lengths of up to nine reads therefore land on both sides of the budget, and on both sides of the moment the timeout flag rises. The 8-bit data width keeps bits 6 and 5 at their usual positions, with random values on the other bits.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;
  localparam int unsigned TOGGLE_BIT  = 6;
  localparam int unsigned TIMEOUT_BIT = 5;
  localparam logic [7:0]  RESET_CMD   = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_RST_WR,
    ST_DONE
  } poll_state_e;
endpackage

// File: rtl/tp_bit_store.sv
module tp_bit_store #(
  parameter int unsigned DW  = 8,
  parameter int unsigned IDX = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic          held_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o  <= 1'b0;
      valid_o <= 1'b0;
    end else if (clr_i) begin
      held_o  <= 1'b0;
      valid_o <= 1'b0;
    end else if (cap_i) begin
      held_o  <= data_i[IDX];
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tp_iter_count.sv
module tp_iter_count #(
  parameter int unsigned MAX = 4,
  localparam int unsigned CW = $clog2(MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX - 1));

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAX));
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import toggle_poll_pkg::*;
#(
  parameter int unsigned AW        = 24,
  parameter int unsigned DW        = 8,
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] poll_addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o
);
  poll_state_e   state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          recheck_q, recheck_d;
  logic          pass_q, pass_d;
  logic          held_bit, held_valid;
  logic          cnt_last, cnt_inc, restart;
  logic          toggled, timed_out, pair_done;

  assign restart   = abort_i || (state_q == ST_IDLE && start_i);
  assign pair_done = (state_q == ST_RD_B) && rd_ack_i;
  assign toggled   = held_bit ^ rd_data_i[TOGGLE_BIT];
  assign timed_out = rd_data_i[TIMEOUT_BIT];

  tp_bit_store #(.DW(DW), .IDX(TOGGLE_BIT)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .cap_i  (state_q == ST_RD_A && rd_ack_i),
    .data_i (rd_data_i),
    .held_o (held_bit),
    .valid_o(held_valid)
  );

  tp_iter_count #(.MAX(MAX_POLLS)) u_iter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .inc_i (cnt_inc),
    .last_o(cnt_last)
  );

  always_comb begin
    state_d   = state_q;
    recheck_d = recheck_q;
    pass_d    = pass_q;
    cnt_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_RD_A;
        recheck_d = 1'b0;
      end
      ST_RD_A: if (rd_ack_i) state_d = ST_RD_B;
      ST_RD_B: if (rd_ack_i) begin
        if (!toggled) begin
          state_d = ST_DONE;
          pass_d  = 1'b1;
        end else if (recheck_q) begin
          state_d = ST_RST_WR;
        end else if (timed_out) begin
          state_d   = ST_RD_A;
          recheck_d = 1'b1;
        end else if (cnt_last) begin
          state_d = ST_RST_WR;
        end else begin
          state_d = ST_RD_A;
          cnt_inc = 1'b1;
        end
      end
      ST_RST_WR: if (wr_ack_i) begin
        state_d = ST_DONE;
        pass_d  = 1'b0;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) begin
      state_d   = ST_IDLE;
      recheck_d = 1'b0;
      cnt_inc   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      recheck_q <= 1'b0;
      pass_q    <= 1'b0;
      addr_q    <= '0;
    end else begin
      state_q   <= state_d;
      recheck_q <= recheck_d;
      pass_q    <= pass_d;
      if (state_q == ST_IDLE && start_i) addr_q <= poll_addr_i;
    end
  end

  assign rd_req_o  = (state_q == ST_RD_A) || (state_q == ST_RD_B);
  assign rd_addr_o = addr_q;
  assign wr_req_o  = (state_q == ST_RST_WR);
  assign wr_addr_o = addr_q;
  assign wr_data_o = DW'(RESET_CMD);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign pass_o    = pass_q;

  assert_pair_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_done |-> held_valid);
  assert_pass_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> $past(rd_req_o && rd_ack_i));
  assert_fail_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> $past(wr_req_o && wr_ack_i));
  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !rd_req_o && !wr_req_o && !done_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && !abort_i) |=> (rd_req_o && $stable(rd_addr_o)));
endmodule

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;
  localparam int unsigned AW   = 16;
  localparam int unsigned DW   = 8;
  localparam int unsigned MAXP = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, abort_i = 1'b0;
  logic [AW-1:0] poll_addr_i = '0;
  logic          rd_req_o, rd_ack_i = 1'b0;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i = '0;
  logic          wr_req_o, wr_ack_i = 1'b0;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic          busy_o, done_o, pass_o;

  int checks = 0, errors = 0;
  int dev_t = 0, dev_f = 1000, dev_n = 0, wait_cnt = 0;
  bit dev_base = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  int addr_err = 0, wr_cnt = 0, done_cnt = 0;
  logic [DW-1:0] wr_seen_data = '0;
  logic [AW-1:0] wr_seen_addr = '0;
  bit finished = 1'b0;

  toggle_poll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .poll_addr_i(poll_addr_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .wr_req_o(wr_req_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o)
  );

  always #2.5 clk_i = ~clk_i;

  function automatic bit tbit(int n, int t, bit base);
    int m = (n < t) ? n : t;
    return base ^ m[0];
  endfunction

  function automatic void predict(int t, int f, output int reads, output bit pass);
    int n = 0, iters = 0;
    bit rc = 0;
    reads = 0; pass = 0;
    for (int k = 0; k < 1000; k++) begin
      bit a = tbit(n, t, 1'b0), b = tbit(n + 1, t, 1'b0);
      bit d5 = (n + 1) >= f;
      n += 2;
      if (a == b) begin pass = 1; break; end
      else if (rc) begin pass = 0; break; end
      else if (d5) rc = 1;
      else begin
        iters++;
        if (iters == MAXP) begin pass = 0; break; end
      end
    end
    reads = n;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural flash status responder
  always @(negedge clk_i) begin
    if (rd_req_o && !rd_ack_i) begin
      if (wait_cnt == 0) begin
        logic [DW-1:0] d = DW'($urandom);
        d[6] = tbit(dev_n, dev_t, dev_base);
        d[5] = (dev_n >= dev_f);
        rd_data_i = d;
        rd_ack_i = 1'b1;
        if (rd_addr_o != exp_addr) addr_err++;
        dev_n++;
        wait_cnt = $urandom % 3;
      end else wait_cnt--;
    end else rd_ack_i = 1'b0;
  end

  always @(negedge clk_i) begin
    if (wr_req_o && !wr_ack_i) begin
      wr_ack_i = 1'b1;
      wr_cnt++;
      wr_seen_data = wr_data_o;
      wr_seen_addr = wr_addr_o;
    end else wr_ack_i = 1'b0;
  end

  always @(negedge clk_i) if (done_o) done_cnt++;

  task automatic dev_setup(int t, int f, bit base, logic [AW-1:0] addr);
    dev_t = t; dev_f = f; dev_base = base; dev_n = 0; wait_cnt = 0;
    wr_cnt = 0; addr_err = 0; exp_addr = addr;
  endtask

  task automatic run_op(int t, int f, bit base, logic [AW-1:0] addr, bit mid, string req);
    int exp_reads, cyc;
    bit exp_pass;
    predict(t, f, exp_reads, exp_pass);
    dev_setup(t, f, base, addr);
    @(negedge clk_i);
    poll_addr_i = addr; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; poll_addr_i = ~addr;
    cyc = 0;
    while (!done_o && cyc < 5000) begin
      start_i = (mid && cyc == 2);
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    check(done_o === 1'b1, req, "done reached", int'(done_o), 1);
    check(pass_o === exp_pass, req, "pass flag", int'(pass_o), int'(exp_pass));
    check(dev_n == exp_reads, req, "read count", dev_n, exp_reads);
    check(wr_cnt == (exp_pass ? 0 : 1), req, "reset write count", wr_cnt, exp_pass ? 0 : 1);
    if (!exp_pass) begin
      check(wr_seen_data == 8'hF0, "R6", "reset write data", int'(wr_seen_data), 'hF0);
      check(wr_seen_addr == addr, "R6", "reset write addr", int'(wr_seen_addr), int'(addr));
    end
    check(addr_err == 0, "R2", "read address mismatches", addr_err, 0);
    @(negedge clk_i);
    check(done_o === 1'b0, "R9", "done width", int'(done_o), 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int dc;
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(busy_o === 0 && rd_req_o === 0 && wr_req_o === 0 && done_o === 0,
          "R1", "idle in reset", int'({busy_o, rd_req_o, wr_req_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(busy_o === 0 && rd_req_o === 0, "R1", "idle after reset",
          int'({busy_o, rd_req_o}), 0);

    run_op(0, 1000, 1'b0, 16'h0A5A, 1'b0, "R3");   // steady: pass in 2 reads (R2)
    run_op(1, 1000, 1'b1, 16'h1234, 1'b0, "R4");   // one toggling pair then steady
    run_op(3, 2, 1'b0, 16'h00FF, 1'b0, "R5");      // flag rises, confirm pair steady
    run_op(100, 1, 1'b0, 16'hBEEF, 1'b0, "R6");    // flag high, still toggling
    run_op(100, 1000, 1'b1, 16'h7777, 1'b0, "R7"); // budget exhausted
    run_op(2, 1000, 1'b0, 16'h4321, 1'b1, "R9");   // start while busy ignored

    // R8 abort after first read, then fresh restart
    dev_setup(100, 1000, 1'b0, 16'h5555);
    @(negedge clk_i);
    poll_addr_i = 16'h5555; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait (dev_n == 1);
    @(negedge clk_i);
    dc = done_cnt;
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    check(!busy_o && !rd_req_o && !wr_req_o, "R8", "idle after abort",
          int'({busy_o, rd_req_o, wr_req_o}), 0);
    repeat (5) @(negedge clk_i);
    check(done_cnt == dc, "R8", "no result after abort", done_cnt - dc, 0);
    check(dev_n == 1, "R8", "no reads after abort", dev_n, 1);
    run_op(0, 1000, 1'b1, 16'h5555, 1'b0, "R8");

    for (int i = 0; i < 24; i++) begin
      int t = $urandom % 10;
      int f = 1 + ($urandom % 14);
      run_op(t, f, 1'($urandom), AW'($urandom), 1'($urandom), "R4");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule